// File: doc/BRIEF.md
# Serial Flash Read Command Engine

This block is the read side of a serial flash slave. A bus master lowers chip select and clocks in an 8-bit opcode and a 24-bit byte address. The engine then streams bytes out of a byte-wide array that sits behind a one-cycle synchronous read port. It handles four read opcodes with one shared shift engine. Each opcode differs in three ways: how many lines carry the address, how many dummy clocks come before data, and whether data leaves on one line or on two.

The serial clock, chip select and both data lines are sampled by the block's own system clock. The block finds serial clock edges by oversampling, so both clock polarities at idle (mode 0 and mode 3) work the same way. Input bits are taken on rising serial clock edges. Output bits change on falling edges. The pins are exposed as value/enable pairs so that the pad ring can build the tri-state drivers.

Top module: `spi_read_engine`

## Requirements
- R1: After reset, and while chip select is high, both output enables are low and no array read is issued.
- R2: Serial clock idle low (mode 0) and idle high (mode 3) produce identical results. Inputs are sampled on rising edges and outputs change on falling edges.
- R3: Opcode 0x03 takes 24 address bits MSB first on IO0. Data follows at once on IO1, one bit per clock, MSB first, with no dummy clocks.
- R4: Opcode 0x0B takes the address as in R3, waits 8 dummy clocks, then sends data one bit per clock on IO1.
- R5: Opcode 0x3B takes the address on IO0, waits 8 dummy clocks, then sends two bits per clock. IO1 carries bits 7, 5, 3, 1 and IO0 carries bits 6, 4, 2, 0.
- R6: Opcode 0xBB takes the address two bits per clock, with IO1 holding the higher bit of each pair. It waits 4 dummy clocks, then sends data as in R5.
- R7: Successive bytes of one transfer come from successive addresses.
- R8: After the top array address (2^MEM_AW - 1), the next byte comes from address 0.
- R9: Address bits at and above bit MEM_AW are ignored.
- R10: Raising chip select aborts a transfer in any phase. Outputs go to high impedance, and the next transfer starts over with a new opcode.
- R11: Any other opcode drives no output and issues no array read until chip select rises.
- R12: Outputs are high impedance outside the data phase. IO0 is never driven by single-line opcodes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Chip select, active low |
| io0_in | input | 1 | Line 0 input (serial data in) |
| io1_in | input | 1 | Line 1 input (used for two-line address) |
| io0_out | output | 1 | Line 0 output value |
| io0_oe | output | 1 | Line 0 output enable |
| io1_out | output | 1 | Line 1 output value (serial data out) |
| io1_oe | output | 1 | Line 1 output enable |
| mem_rd | output | 1 | Array read strobe, one cycle |
| mem_addr | output | MEM_AW | Array byte address |
| mem_data | input | 8 | Array read data, valid the cycle after mem_rd |

## Verification
Each of the four opcodes runs in both clock polarities. The transfers use differing start addresses and byte counts, so that lane order, dummy length and address increment can be told apart: a wrong dummy count shifts every byte by whole bits, and swapped lanes swap adjacent bit pairs. The array model returns a value mixed from all three address bytes. Because of that, a missing increment, a missing wrap, or leaked upper address bits each produce a wrong byte. Directed cases cover an abort in the middle of a byte followed by a fresh transfer, and an unknown opcode, where the bench watches both output enables and the read strobe.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  localparam int ADDR_BITS = 24;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FAST  = 8'h0B;
  localparam logic [7:0] OP_DOUT  = 8'h3B;
  localparam logic [7:0] OP_DIO   = 8'hBB;

  typedef enum logic [2:0] {PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA, PH_SKIP} phase_t;

  typedef struct packed {
    logic       valid;
    logic       addr_dual;
    logic       data_dual;
    logic [3:0] dummy;
  } rd_cfg_t;

  function automatic rd_cfg_t decode_op(input logic [7:0] op);
    rd_cfg_t c;
    c = '{valid: 1'b0, addr_dual: 1'b0, data_dual: 1'b0, dummy: 4'd0};
    case (op)
      OP_READ: c.valid = 1'b1;
      OP_FAST: begin c.valid = 1'b1; c.dummy = 4'd8; end
      OP_DOUT: begin c.valid = 1'b1; c.dummy = 4'd8; c.data_dual = 1'b1; end
      OP_DIO:  begin c.valid = 1'b1; c.dummy = 4'd4; c.data_dual = 1'b1; c.addr_dual = 1'b1; end
      default: c.valid = 1'b0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/spi_rd_front.sv
module spi_rd_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic io0_in,
  input  logic io1_in,
  output logic rise,
  output logic fall,
  output logic active,
  output logic s_io0,
  output logic s_io1
);
  localparam int W = 4;
  localparam logic [W-1:0] RST_VAL = 4'b0010;

  logic [W-1:0] din;
  logic [W-1:0] sync_q;
  logic         sck_last_q;

  assign din = {io1_in, io0_in, cs_n, sck};

  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] pipe_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL[b]}};
        else        pipe_q <= {pipe_q[STAGES-2:0], din[b]};
      end
      assign sync_q[b] = pipe_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_last_q <= 1'b0;
    else        sck_last_q <= sync_q[0];
  end

  assign active = ~sync_q[1];
  assign rise   = active & sync_q[0] & ~sck_last_q;
  assign fall   = active & ~sync_q[0] & sck_last_q;
  assign s_io0  = sync_q[2];
  assign s_io1  = sync_q[3];
endmodule

// File: rtl/spi_rd_ctrl.sv
module spi_rd_ctrl
  import spi_rd_pkg::*;
#(
  parameter int MEM_AW = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              fall,
  input  logic              active,
  input  logic              s_io0,
  input  logic              s_io1,
  output logic              load,
  output logic              step,
  output logic              dual,
  output logic              data_en,
  output logic              mem_rd,
  output logic [MEM_AW-1:0] mem_addr
);
  localparam logic [4:0] A_LAST_1 = 5'(ADDR_BITS - 1);
  localparam logic [4:0] A_LAST_2 = 5'(ADDR_BITS / 2 - 1);
  localparam logic [2:0] F_LAST_1 = 3'd7;
  localparam logic [2:0] F_LAST_2 = 3'd3;

  phase_t                 phase_q, phase_d;
  logic [4:0]             cnt_q, cnt_d;
  logic [7:0]             opsh_q, opsh_d;
  rd_cfg_t                cfg_q, cfg_d;
  logic [ADDR_BITS-1:0]   ash_q, ash_d;
  logic [MEM_AW-1:0]      ptr_q, ptr_d;
  logic [2:0]             fcnt_q, fcnt_d;
  logic                   rd_q, rd_d;
  logic [MEM_AW-1:0]      raddr_q, raddr_d;
  logic [2:0]             f_last;

  assign f_last = cfg_q.data_dual ? F_LAST_2 : F_LAST_1;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    opsh_d  = opsh_q;
    cfg_d   = cfg_q;
    ash_d   = ash_q;
    ptr_d   = ptr_q;
    fcnt_d  = fcnt_q;
    rd_d    = 1'b0;
    raddr_d = raddr_q;
    load    = 1'b0;
    step    = 1'b0;
    if (!active) begin
      phase_d = PH_CMD;
      cnt_d   = '0;
      fcnt_d  = '0;
    end else begin
      case (phase_q)
        PH_CMD: if (rise) begin
          opsh_d = {opsh_q[6:0], s_io0};
          cnt_d  = cnt_q + 5'd1;
          if (cnt_q == 5'd7) begin
            cfg_d   = decode_op(opsh_d);
            cnt_d   = '0;
            phase_d = cfg_d.valid ? PH_ADDR : PH_SKIP;
          end
        end
        PH_ADDR: if (rise) begin
          ash_d = cfg_q.addr_dual ? {ash_q[ADDR_BITS-3:0], s_io1, s_io0}
                                  : {ash_q[ADDR_BITS-2:0], s_io0};
          cnt_d = cnt_q + 5'd1;
          if (cnt_q == (cfg_q.addr_dual ? A_LAST_2 : A_LAST_1)) begin
            cnt_d = '0;
            ptr_d = ash_d[MEM_AW-1:0];
            if (cfg_q.dummy == 4'd0) begin
              phase_d = PH_DATA;
              rd_d    = 1'b1;
              raddr_d = ptr_d;
            end else begin
              phase_d = PH_DUMMY;
            end
          end
        end
        PH_DUMMY: if (rise) begin
          cnt_d = cnt_q + 5'd1;
          if (cnt_q == {1'b0, cfg_q.dummy} - 5'd1) begin
            cnt_d   = '0;
            phase_d = PH_DATA;
            rd_d    = 1'b1;
            raddr_d = ptr_q;
          end
        end
        PH_DATA: if (fall) begin
          if (fcnt_q == 3'd0) begin
            load    = 1'b1;
            ptr_d   = ptr_q + 1'b1;
            rd_d    = 1'b1;
            raddr_d = ptr_d;
          end else begin
            step = 1'b1;
          end
          fcnt_d = (fcnt_q == f_last) ? 3'd0 : fcnt_q + 3'd1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      cnt_q   <= '0;
      opsh_q  <= '0;
      cfg_q   <= '0;
      ash_q   <= '0;
      ptr_q   <= '0;
      fcnt_q  <= '0;
      rd_q    <= 1'b0;
      raddr_q <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      opsh_q  <= opsh_d;
      cfg_q   <= cfg_d;
      ash_q   <= ash_d;
      ptr_q   <= ptr_d;
      fcnt_q  <= fcnt_d;
      rd_q    <= rd_d;
      raddr_q <= raddr_d;
    end
  end

  assign dual     = cfg_q.data_dual;
  assign data_en  = active && (phase_q == PH_DATA);
  assign mem_rd   = rd_q;
  assign mem_addr = raddr_q;

  assert_read_only_in_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> phase_q == PH_DATA);
  assert_valid_op_in_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_DATA |-> cfg_q.valid);
  assert_data_after_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_q == PH_DATA) |-> ($past(phase_q) == PH_ADDR || $past(phase_q) == PH_DUMMY));
  assert_prefetch_on_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> mem_rd);
  assert_abort_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> phase_q == PH_CMD);
endmodule

// File: rtl/spi_rd_tx.sv
module spi_rd_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       step,
  input  logic       dual,
  input  logic       data_en,
  input  logic       mem_rd,
  input  logic [7:0] mem_data,
  output logic       io0_out,
  output logic       io0_oe,
  output logic       io1_out,
  output logic       io1_oe
);
  logic       rd_vld_q;
  logic [7:0] buf_q, buf_d;
  logic [7:0] sr_q, sr_d;
  logic       drv_q, drv_d;
  logic       dual_q, dual_d;

  always_comb begin
    buf_d  = rd_vld_q ? mem_data : buf_q;
    sr_d   = sr_q;
    dual_d = dual_q;
    if (load) begin
      sr_d   = buf_q;
      dual_d = dual;
    end else if (step) begin
      sr_d = dual_q ? {sr_q[5:0], 2'b00} : {sr_q[6:0], 1'b0};
    end
    drv_d = load ? 1'b1 : (data_en ? drv_q : 1'b0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld_q <= 1'b0;
      buf_q    <= '0;
      sr_q     <= '0;
      drv_q    <= 1'b0;
      dual_q   <= 1'b0;
    end else begin
      rd_vld_q <= mem_rd;
      buf_q    <= buf_d;
      sr_q     <= sr_d;
      drv_q    <= drv_d;
      dual_q   <= dual_d;
    end
  end

  assign io1_oe  = drv_q;
  assign io0_oe  = drv_q & dual_q;
  assign io1_out = drv_q & sr_q[7];
  assign io0_out = drv_q & dual_q & sr_q[6];

  assert_hiz_outside_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !data_en |=> (!io1_oe && !io0_oe));
  assert_io0_only_dual_R12: assert property (@(posedge clk) disable iff (!rst_n)
    io0_oe |-> io1_oe);
endmodule

// File: rtl/spi_read_engine.sv
module spi_read_engine #(
  parameter int MEM_AW      = 23,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              io0_in,
  input  logic              io1_in,
  output logic              io0_out,
  output logic              io0_oe,
  output logic              io1_out,
  output logic              io1_oe,
  output logic              mem_rd,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [7:0]        mem_data
);
  logic [1:0] rst_pipe_q;
  logic       rst_sn;
  logic       rise, fall, active, s_io0, s_io1;
  logic       load, step, dual, data_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  spi_rd_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_sn), .sck(sck), .cs_n(cs_n),
    .io0_in(io0_in), .io1_in(io1_in),
    .rise(rise), .fall(fall), .active(active), .s_io0(s_io0), .s_io1(s_io1)
  );

  spi_rd_ctrl #(.MEM_AW(MEM_AW)) u_ctrl (
    .clk(clk), .rst_n(rst_sn), .rise(rise), .fall(fall), .active(active),
    .s_io0(s_io0), .s_io1(s_io1), .load(load), .step(step), .dual(dual),
    .data_en(data_en), .mem_rd(mem_rd), .mem_addr(mem_addr)
  );

  spi_rd_tx u_tx (
    .clk(clk), .rst_n(rst_sn), .load(load), .step(step), .dual(dual),
    .data_en(data_en), .mem_rd(mem_rd), .mem_data(mem_data),
    .io0_out(io0_out), .io0_oe(io0_oe), .io1_out(io1_out), .io1_oe(io1_oe)
  );

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) |-> (!io1_oe && !io0_oe && !mem_rd));
endmodule

// File: tb/spi_read_engine_test.sv
module spi_read_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 8;
  localparam int AW         = 23;
  localparam int NVEC       = 8;
  // {mode3, opcode, address, byte count}
  localparam logic [40:0] VEC [NVEC] = '{
    {1'b0, 8'h03, 24'h000100, 8'd4},
    {1'b1, 8'h03, 24'h123456, 8'd3},
    {1'b0, 8'h0B, 24'h00ABCD, 8'd3},
    {1'b1, 8'h0B, 24'h400000, 8'd2},
    {1'b0, 8'h3B, 24'h0000F0, 8'd4},
    {1'b1, 8'h3B, 24'h7FFFFE, 8'd4},
    {1'b0, 8'hBB, 24'h5A5A5A, 8'd4},
    {1'b1, 8'hBB, 24'hFFFFFF, 8'd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic io0_in = 1'b0;
  logic io1_in = 1'b0;
  logic io0_out, io0_oe, io1_out, io1_oe, mem_rd;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_data = 8'h00;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int rd_cnt = 0;
  logic [7:0] got [16];
  int bad_setup, bad_lane, oe_any, last_oe;

  spi_read_engine #(.MEM_AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
    .io0_in(io0_in), .io1_in(io1_in),
    .io0_out(io0_out), .io0_oe(io0_oe), .io1_out(io1_out), .io1_oe(io1_oe),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] emem(input logic [AW-1:0] a);
    return a[7:0] + (a[15:8] << 1) + a[15:8] + (8'(a[22:16]) << 2) + 8'(a[22:16]);
  endfunction

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_data <= emem(mem_addr);
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      checks = checks + 1;
      fails = fails + 1;
      $display("FAIL R1 watchdog: actual=%0d cycles expected below %0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int lanes_of(input logic [7:0] op);
    return (op == 8'h3B || op == 8'hBB) ? 2 : 1;
  endfunction

  function automatic int setup_of(input logic [7:0] op);
    int s;
    s = 8 + ((op == 8'hBB) ? 12 : 24);
    if (op == 8'h0B || op == 8'h3B) s = s + 8;
    if (op == 8'hBB) s = s + 4;
    return s;
  endfunction

  // limit < 0 means run the full transfer
  task automatic xfer(input bit m3, input logic [7:0] op, input logic [23:0] a, input int nb, input int limit);
    int lanes, setup, dclk, total, per;
    logic [7:0] cur;
    lanes = lanes_of(op);
    setup = setup_of(op);
    per = 8 / lanes;
    dclk = nb * per;
    total = (limit < 0) ? setup + dclk : limit;
    cur = 8'h00;
    bad_setup = 0; bad_lane = 0; oe_any = 0; last_oe = 0;
    @(negedge clk);
    sck = m3;
    repeat (3) @(negedge clk);
    cs_n = 1'b0;
    if (m3) begin
      repeat (H) @(negedge clk);
      sck = 1'b0;
    end
    for (int k = 0; k < total; k++) begin
      if (k < 8) begin
        io0_in = op[7-k]; io1_in = 1'b0;
      end else if (k < 8 + 24 / ((op == 8'hBB) ? 2 : 1)) begin
        if (op == 8'hBB) begin
          io1_in = a[23 - 2*(k-8)]; io0_in = a[22 - 2*(k-8)];
        end else begin
          io0_in = a[23 - (k-8)]; io1_in = 1'b0;
        end
      end else begin
        io0_in = 1'b0; io1_in = 1'b0;
      end
      repeat (H) @(negedge clk);
      if (io1_oe || io0_oe) oe_any = oe_any + 1;
      last_oe = io1_oe;
      if (k < setup) begin
        if (io1_oe || io0_oe) bad_setup = bad_setup + 1;
      end else begin
        if (!io1_oe || (io0_oe != (lanes == 2))) bad_lane = bad_lane + 1;
        cur = (lanes == 2) ? {cur[5:0], io1_out, io0_out} : {cur[6:0], io1_out};
        if (((k - setup + 1) % per) == 0) got[(k - setup) / per] = cur;
      end
      sck = 1'b1;
      repeat (H) @(negedge clk);
      sck = 1'b0;
    end
    repeat (H) @(negedge clk);
    if (m3) sck = 1'b1;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  function automatic string tag_of(input logic [7:0] op, input int v);
    string t;
    case (op)
      8'h03: t = "R3";
      8'h0B: t = "R4";
      8'h3B: t = "R5";
      default: t = "R6";
    endcase
    if (v % 2 == 1) t = {t, " R2"};
    if (v == 5) t = {t, " R8"};
    if (v == 7) t = {t, " R9 R8"};
    return {t, " R7"};
  endfunction

  initial begin
    int rd0;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(!io1_oe && !io0_oe, "R1 oe during reset", {io1_oe, io0_oe}, 0);
    chk(!mem_rd, "R1 read during reset", mem_rd, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(!io1_oe && !io0_oe && !mem_rd, "R1 idle after reset", {io1_oe, io0_oe, mem_rd}, 0);

    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] op;
      logic [23:0] a;
      int nb;
      op = VEC[v][39:32];
      a  = VEC[v][31:8];
      nb = int'(VEC[v][7:0]);
      xfer(VEC[v][40], op, a, nb, -1);
      for (int j = 0; j < nb; j++) begin
        logic [AW-1:0] ea;
        ea = a[AW-1:0] + AW'(j);
        chk(got[j] == emem(ea), $sformatf("%s vec %0d byte %0d", tag_of(op, v), v, j), got[j], emem(ea));
      end
      chk(bad_setup == 0, $sformatf("R12 vec %0d oe before data", v), bad_setup, 0);
      chk(bad_lane == 0, $sformatf("R12 vec %0d lane enables in data", v), bad_lane, 0);
      chk(!io1_oe && !io0_oe, $sformatf("R1 vec %0d oe after cs high", v), {io1_oe, io0_oe}, 0);
    end

    // R10: abort mid-byte, then a fresh transfer
    xfer(1'b0, 8'h03, 24'h000200, 2, 32 + 3);
    chk(last_oe == 1, "R10 driving before abort", last_oe, 1);
    chk(!io1_oe && !io0_oe, "R10 hi-z after abort", {io1_oe, io0_oe}, 0);
    xfer(1'b1, 8'h0B, 24'h000300, 2, -1);
    chk(got[0] == emem(23'h000300), "R10 restart byte 0", got[0], emem(23'h000300));
    chk(got[1] == emem(23'h000301), "R10 restart byte 1", got[1], emem(23'h000301));

    // R10: abort during the address phase, then a dual read
    xfer(1'b0, 8'hBB, 24'h111111, 1, 8 + 5);
    xfer(1'b0, 8'h3B, 24'h020304, 2, -1);
    chk(got[0] == emem(23'h020304), "R10 restart after addr abort", got[0], emem(23'h020304));

    // R11: unknown opcode
    rd0 = rd_cnt;
    xfer(1'b0, 8'h9F, 24'h000000, 4, 8 + 24 + 32);
    chk(oe_any == 0, "R11 no drive on unknown opcode", oe_any, 0);
    chk(rd_cnt == rd0, "R11 no read on unknown opcode", rd_cnt - rd0, 0);

    // R9: top address bits ignored, single line
    xfer(1'b0, 8'h03, 24'h800005, 1, -1);
    chk(got[0] == emem(23'h000005), "R9 upper bit ignored", got[0], emem(23'h000005));

    summary();
    $finish;
  end
endmodule